// File: doc/BRIEF.md
# Unreachable-State Forcing Register

This block is the state register of a controller plus a small piece of forcing logic in front of it. The next-state word from the controller's logic arrives on `nxt_state`. A few control pins may modify that word before it is captured, so that a test can place the machine in a state that ordinary transitions from reset never produce. With every control pin low, the next state passes straight through and the machine behaves exactly as it would without the block.

Each control pin has three `STATE_W`-bit masks, fixed at elaboration: bits to force high, bits to force low and bits to invert. The masks of all active controls merge: all set masks are ORed, all clear masks are ORed and all toggle masks are XORed. The word is first forced high, then forced low, then toggled. A hold pin freezes the register at its present value whatever the next-state word or controls carry. That lets a test keep the machine in one state while it applies many input patterns. There is no streaming data path. All pins are plain level signals and there is no back-pressure.

Top module: `state_force_reg`

## Requirements
- R1: When `ctrl` is all zero, `load_val` equals `nxt_state` bit for bit.
- R2: A bit named in the set mask of any active control is 1 in `load_val` unless a clear or toggle also applies to it.
- R3: A bit named in the clear mask of any active control is 0 before toggling, even when another active control sets the same bit.
- R4: Toggles apply after set and clear. Each active toggle mask inverts its bits, so two active controls that toggle the same bit leave it untoggled.
- R5: With the default masks (control 0: set 4'b0100, clear 4'b0010; control 1: set 4'b0001, clear 4'b0100, toggle 4'b1000; control 2: toggle 4'b1001; bit 3 is the MSB), `ctrl`=3'b001 turns `nxt_state` 4'b0011 into `load_val` 4'b0101.
- R6: With the default masks, several active controls combine as stated in R2 to R4. `ctrl`=3'b011 on 4'b1111 gives 4'b0001, 3'b110 on 4'b0000 gives 4'b0000 and 3'b111 on 4'b1010 gives 4'b1000.
- R7: While `hold` is high and `rst` is low, `state_q` keeps its value at every clock edge, whatever `nxt_state` and `ctrl` carry.
- R8: `rst` high at a clock edge loads `RESET_STATE` (default 4'b0001) into `state_q`, even when `hold` is high.
- R9: With `rst` and `hold` low, `state_q` takes the value `load_val` had just before each clock edge.
- R10: `load_val` is combinational: it reflects `nxt_state` and `ctrl` in the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| hold | input | 1 | Freeze the state register |
| ctrl | input | NUM_CTRL | Forcing controls, one per mask set |
| nxt_state | input | STATE_W | Next-state word from the controller logic |
| load_val | output | STATE_W | Value offered to the state register |
| state_q | output | STATE_W | Present state |

## Verification
The assertions check four behaviours on every cycle: the pass-through with all controls low, the freeze during hold, the reset value and its priority over hold, and the capture of `load_val` when neither reset nor hold is active. The bench's directed scenarios cover the mask arithmetic. That includes clear winning over set, toggle applied last and toggles cancelling each other. It also covers the worked forcing case and hold while controls and the next state change, because the correct result there depends on the chosen mask values rather than on a rule that holds on every cycle.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  typedef enum logic [1:0] {
    ACT_RESET = 2'd0,
    ACT_HOLD  = 2'd1,
    ACT_LOAD  = 2'd2
  } reg_act_e;
endpackage

// File: rtl/sfr_mask_gather.sv
module sfr_mask_gather #(
  parameter int W = 4,
  parameter int N = 3,
  parameter logic [N*W-1:0] SET_M = '0,
  parameter logic [N*W-1:0] CLR_M = '0,
  parameter logic [N*W-1:0] TGL_M = '0
) (
  input  logic [N-1:0] ctrl,
  output logic [W-1:0] set_any,
  output logic [W-1:0] clr_any,
  output logic [W-1:0] tgl_par
);
  logic [N-1:0][W-1:0] set_g;
  logic [N-1:0][W-1:0] clr_g;
  logic [N-1:0][W-1:0] tgl_g;

  // One gated mask triple per control line
  for (genvar c = 0; c < N; c++) begin : g_ctrl
    localparam logic [W-1:0] S_C = SET_M[c*W +: W];
    localparam logic [W-1:0] C_C = CLR_M[c*W +: W];
    localparam logic [W-1:0] T_C = TGL_M[c*W +: W];
    assign set_g[c] = S_C & {W{ctrl[c]}};
    assign clr_g[c] = C_C & {W{ctrl[c]}};
    assign tgl_g[c] = T_C & {W{ctrl[c]}};
  end

  // Sets and clears merge by OR, toggles by parity
  always_comb begin
    set_any = '0;
    clr_any = '0;
    tgl_par = '0;
    for (int c = 0; c < N; c++) begin
      set_any = set_any | set_g[c];
      clr_any = clr_any | clr_g[c];
      tgl_par = tgl_par ^ tgl_g[c];
    end
  end
endmodule

// File: rtl/sfr_bit_apply.sv
module sfr_bit_apply #(
  parameter int W = 4
) (
  input  logic [W-1:0] nxt,
  input  logic [W-1:0] set_any,
  input  logic [W-1:0] clr_any,
  input  logic [W-1:0] tgl_par,
  output logic [W-1:0] forced
);
  // Set, then clear, then toggle, per bit
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic after_set;
    logic after_clr;
    assign after_set = nxt[b] | set_any[b];
    assign after_clr = after_set & ~clr_any[b];
    assign forced[b] = after_clr ^ tgl_par[b];
  end
endmodule

// File: rtl/sfr_state_reg.sv
module sfr_state_reg
  import sfr_pkg::*;
#(
  parameter int W = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  reg_act_e act;

  // Reset outranks hold, hold outranks load
  always_comb begin
    if (rst)       act = ACT_RESET;
    else if (hold) act = ACT_HOLD;
    else           act = ACT_LOAD;
  end

  always_ff @(posedge clk) begin
    case (act)
      ACT_RESET: q <= RST_VAL;
      ACT_HOLD:  q <= q;
      default:   q <= d;
    endcase
  end
endmodule

// File: rtl/state_force_reg.sv
module state_force_reg #(
  parameter int STATE_W = 4,
  parameter int NUM_CTRL = 3,
  parameter logic [STATE_W-1:0] RESET_STATE = 4'b0001,
  parameter logic [NUM_CTRL*STATE_W-1:0] SET_MASKS = 12'h014,
  parameter logic [NUM_CTRL*STATE_W-1:0] CLR_MASKS = 12'h042,
  parameter logic [NUM_CTRL*STATE_W-1:0] TGL_MASKS = 12'h980
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                hold,
  input  logic [NUM_CTRL-1:0] ctrl,
  input  logic [STATE_W-1:0]  nxt_state,
  output logic [STATE_W-1:0]  load_val,
  output logic [STATE_W-1:0]  state_q
);
  logic [STATE_W-1:0] set_any;
  logic [STATE_W-1:0] clr_any;
  logic [STATE_W-1:0] tgl_par;

  sfr_mask_gather #(
    .W(STATE_W), .N(NUM_CTRL),
    .SET_M(SET_MASKS), .CLR_M(CLR_MASKS), .TGL_M(TGL_MASKS)
  ) u_gather (
    .ctrl(ctrl), .set_any(set_any), .clr_any(clr_any), .tgl_par(tgl_par)
  );

  sfr_bit_apply #(.W(STATE_W)) u_apply (
    .nxt(nxt_state), .set_any(set_any), .clr_any(clr_any),
    .tgl_par(tgl_par), .forced(load_val)
  );

  sfr_state_reg #(.W(STATE_W), .RST_VAL(RESET_STATE)) u_reg (
    .clk(clk), .rst(rst), .hold(hold), .d(load_val), .q(state_q)
  );
endmodule

// File: rtl/sfr_checker.sv
module sfr_checker #(
  parameter int STATE_W = 4,
  parameter int NUM_CTRL = 3,
  parameter logic [STATE_W-1:0] RESET_STATE = '0
) (
  input logic                clk,
  input logic                rst,
  input logic                hold,
  input logic [NUM_CTRL-1:0] ctrl,
  input logic [STATE_W-1:0]  nxt_state,
  input logic [STATE_W-1:0]  load_val,
  input logic [STATE_W-1:0]  state_q
);
  p_transparent_r1: assert property (@(posedge clk) disable iff (rst)
    (ctrl == '0) |-> (load_val == nxt_state));

  p_freeze_r7: assert property (@(posedge clk) disable iff (rst)
    hold |=> (state_q == $past(state_q)));

  p_reset_wins_r8: assert property (@(posedge clk)
    rst |=> (state_q == RESET_STATE));

  p_capture_r9: assert property (@(posedge clk) disable iff (rst)
    !hold |=> (state_q == $past(load_val)));
endmodule

bind state_force_reg sfr_checker #(
  .STATE_W(STATE_W), .NUM_CTRL(NUM_CTRL), .RESET_STATE(RESET_STATE)
) i_sfr_checker (
  .clk(clk), .rst(rst), .hold(hold), .ctrl(ctrl),
  .nxt_state(nxt_state), .load_val(load_val), .state_q(state_q)
);

// File: tb/test_state_force_reg.sv
module test_state_force_reg;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hold = 1'b0;
  logic [2:0] ctrl = '0;
  logic [3:0] nxt_state = '0;
  logic [3:0] load_val;
  logic [3:0] state_q;
  int n_checks = 0;
  int n_errs = 0;

  always #2 clk = ~clk;

  state_force_reg i_state_force_reg (
    .clk(clk), .rst(rst), .hold(hold), .ctrl(ctrl),
    .nxt_state(nxt_state), .load_val(load_val), .state_q(state_q)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  // Apply inputs after a falling edge, look at load_val before the rising edge
  task automatic drive(input logic [2:0] c, input logic [3:0] n);
    @(negedge clk);
    ctrl = c;
    nxt_state = n;
    #1;
  endtask

  task automatic t_reset();
    rst = 1'b1; hold = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R8 reset value", state_q, 4'b0001);
    rst = 1'b0;
  endtask

  task automatic t_transparent();
    for (int v = 0; v < 16; v += 5) begin
      drive(3'b000, 4'(v));
      check("R1 pass-through", load_val, 4'(v));
      check("R10 same-cycle", load_val, 4'(v));
    end
  endtask

  task automatic t_worked();
    drive(3'b001, 4'b0011);
    check("R5 worked case", load_val, 4'b0101);
    @(negedge clk);
    check("R9 forced value captured", state_q, 4'b0101);
  endtask

  task automatic t_single();
    drive(3'b010, 4'b0000);
    check("R2 set then R4 toggle", load_val, 4'b1001);
    drive(3'b100, 4'b0110);
    check("R4 toggle only", load_val, 4'b1111);
    drive(3'b001, 4'b1010);
    check("R2 set bit2 R3 clear bit1", load_val, 4'b1100);
  endtask

  task automatic t_multi();
    drive(3'b011, 4'b1111);
    check("R3 clear beats set / R6", load_val, 4'b0001);
    drive(3'b110, 4'b0000);
    check("R4 toggles cancel / R6", load_val, 4'b0000);
    drive(3'b111, 4'b1010);
    check("R6 all three", load_val, 4'b1000);
    @(negedge clk);
    check("R9 capture combined", state_q, 4'b1000);
  endtask

  task automatic t_hold();
    drive(3'b000, 4'b0110);
    @(negedge clk);
    check("R9 load before hold", state_q, 4'b0110);
    hold = 1'b1;
    drive(3'b111, 4'b1011);
    @(negedge clk);
    check("R7 hold vs forcing", state_q, 4'b0110);
    drive(3'b000, 4'b0001);
    @(negedge clk);
    check("R7 hold vs next state", state_q, 4'b0110);
    hold = 1'b0;
    @(negedge clk);
    check("R9 release hold", state_q, 4'b0001);
  endtask

  task automatic t_reset_over_hold();
    drive(3'b000, 4'b1110);
    @(negedge clk);
    check("R9 pre-reset load", state_q, 4'b1110);
    hold = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    check("R8 reset beats hold", state_q, 4'b0001);
    rst = 1'b0;
    hold = 1'b0;
  endtask

  initial begin
    t_reset();
    t_transparent();
    t_worked();
    t_single();
    t_multi();
    t_hold();
    t_reset_over_hold();
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    #20000;
    n_errs++;
    n_checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule